// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block carries out one Clause 22 station-management frame on an MDIO bus each time software writes a 32-bit command word. The command word holds, from the top down, a start pattern, a read or write operation, a five-bit PHY address, a five-bit register number, a turnaround pattern and sixteen data bits. The frame on the wire is 32 preamble ones followed by that word, most significant bit first. The same word can be read back. When a read finishes, its low sixteen bits hold the value returned by the PHY.

The management clock is made by dividing the system clock by a ratio picked with a two-bit code. The ratio is latched when a frame is accepted. Each MDC period starts with a low half and ends with a high half. The controller changes MDIO at the start of each period and samples it at the rising MDC edge. An idle flag tells software when a new command may be written. Writes that arrive while a frame is running, or while the port is disabled, are dropped.

The frame sequencer has five states. `ST_IDLE` moves to `ST_PRE` on an accepted write (transition *accept*). `ST_PRE` sends 32 ones and moves to `ST_HDR` after bit 31 (*preamble done*). `ST_HDR` sends start, opcode and both addresses and moves to `ST_TURN` after bit 45 (*header done*). `ST_TURN` covers the two turnaround bits and moves to `ST_DATA` after bit 47 (*turnaround done*). `ST_DATA` moves the sixteen data bits and returns to `ST_IDLE` after bit 63 (*frame done*).

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: With `mgmt_en` high and `mgmt_idle` high, a one-cycle `maint_wr` starts a frame. `mgmt_idle` reads 0 on the next cycle, and `maint_rdata` holds the written word.
- R2: A `maint_wr` that arrives while `mgmt_idle` is 0, or while `mgmt_en` is 0, is ignored. The running frame, `maint_rdata` and `mgmt_idle` are unaffected, and no new frame starts.
- R3: `mgmt_idle` stays 0 for exactly 64 MDC periods per frame and then returns to 1.
- R4: The divider code picks the system-clock cycles per MDC period: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 48. Each period is low for its first half and high for its second half, and the code is sampled when the frame is accepted.
- R5: For a write (command bit 29 = 0), MDIO is driven for all 64 bits. The driven bits are 32 ones, then command bits 31 down to 0: start in bits 31:30, opcode in 29:28, PHY address in 27:23, register in 22:18, turnaround in 17:16 and data in 15:0.
- R6: For a read (command bit 29 = 1), MDIO is driven only for the first 46 bits (preamble through register number). It is released for the turnaround and data bits.
- R7: During a read's data bits, MDIO is sampled at each rising MDC edge, most significant bit first. At frame end the sixteen sampled bits replace `maint_rdata[15:0]`, and `maint_rdata[31:16]` keeps the command.
- R8: When no PHY answers a read and the bus is pulled high, the read returns 16'hFFFF in `maint_rdata[15:0]`.
- R9: While idle, `mdc` is 0 and `mdio_oe` is 0.
- R10: After reset, `mgmt_idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `maint_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management port enable; writes are accepted only when high |
| mdc_div_sel | input | 2 | MDC divider code |
| maint_wr | input | 1 | One-cycle write strobe for the command word |
| maint_wdata | input | 32 | Command word |
| maint_rdata | output | 32 | Held command word; read data in the low half after a read |
| mgmt_idle | output | 1 | High when no frame is running |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The frame-length assertion assumes the divider code is read only at acceptance, so the stimulus changes `mdc_div_sel` only between frames. Mid-frame writes are still applied to show they are ignored. The read-sampling checks assume `mdio_i` is stable around each rising MDC edge. The bench's PHY model therefore changes `mdio_i` only on falling MDC edges and holds it high (pull-up) whenever no PHY is selected. Write strobes are single-cycle pulses driven on the falling system-clock edge, so every assertion sees clean, settled inputs.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LAST  = 45;
    localparam int TURN_LAST = 47;
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 16;
    localparam int RD_BIT    = 29;

    localparam int DIV_CODE0 = 8;
    localparam int DIV_CODE1 = 16;
    localparam int DIV_CODE2 = 32;
    localparam int DIV_CODE3 = 48;
    localparam int MAX_DIV   = 48;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } mdio_phase_e;

    function automatic int unsigned div_ratio(input logic [1:0] code);
        int unsigned r;
        unique case (code)
            2'd0:    r = DIV_CODE0;
            2'd1:    r = DIV_CODE1;
            2'd2:    r = DIV_CODE2;
            default: r = DIV_CODE3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
    import mdio_mgmt_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       active,
    input  logic [1:0] div_code,
    output logic       mdc,
    output logic       rise_tick,
    output logic       bit_tick
);

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    assign half      = div_q >> 1;
    assign rise_tick = active && (cnt == half - 1'b1);
    assign bit_tick  = active && (cnt == div_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= CNT_W'(DIV_CODE0);
            cnt   <= '0;
            mdc   <= 1'b0;
        end else if (start) begin
            div_q <= CNT_W'(div_ratio(div_code));
            cnt   <= '0;
            mdc   <= 1'b0;
        end else if (!active || bit_tick) begin
            cnt   <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_tick)
                mdc <= 1'b1;
        end
    end

    // R9
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mdc);

    // R4
    mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(active));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              port_en,
    input  logic              rise_tick,
    input  logic              bit_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              start,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [CMD_W-1:0]  maint_q
);

    localparam int IDX_W = $clog2(FRAME_LEN);

    mdio_phase_e        state, nxt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  shin;
    logic               is_read;

    assign is_read = maint_q[RD_BIT];
    assign start   = wr_req && port_en && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_PRE;
            ST_PRE:  if (bit_tick && idx == IDX_W'(PRE_LEN - 1))   nxt = ST_HDR;
            ST_HDR:  if (bit_tick && idx == IDX_W'(HDR_LAST))      nxt = ST_TURN;
            ST_TURN: if (bit_tick && idx == IDX_W'(TURN_LAST))     nxt = ST_DATA;
            ST_DATA: if (bit_tick && idx == IDX_W'(FRAME_LEN - 1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            maint_q <= '0;
            shin    <= '0;
        end else if (start) begin
            idx     <= '0;
            maint_q <= wr_data;
            shin    <= '0;
        end else if (state != ST_IDLE) begin
            if (rise_tick && state == ST_DATA && is_read)
                shin <= {shin[DATA_W-2:0], mdio_i};
            if (bit_tick) begin
                idx <= idx + 1'b1;
                if (state == ST_DATA && idx == IDX_W'(FRAME_LEN - 1) && is_read)
                    maint_q[DATA_W-1:0] <= shin;
            end
        end
    end

    always_comb begin
        busy    = 1'b1;
        mdio_o  = 1'b1;
        mdio_oe = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PRE: mdio_o = 1'b1;
            ST_HDR: mdio_o = maint_q[~idx[4:0]];
            ST_TURN, ST_DATA: begin
                mdio_o  = maint_q[~idx[4:0]];
                mdio_oe = !is_read;
            end
            default: begin
                busy    = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    // R1
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_req && port_en));

    // R2
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(maint_q[CMD_W-1:DATA_W]));

    // R6
    rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && is_read) |-> (idx <= IDX_W'(HDR_LAST)));

    // R9
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_en,
    input  logic [1:0]  mdc_div_sel,
    input  logic        maint_wr,
    input  logic [31:0] maint_wdata,
    output logic [31:0] maint_rdata,
    output logic        mgmt_idle,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int DIV_W = $clog2(MAX_DIV + 1);
    localparam int CYC_W = $clog2(FRAME_LEN * MAX_DIV + 1);

    logic busy, start, rise_tick, bit_tick;

    mdio_clk_gen #(.CNT_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (busy),
        .div_code  (mdc_div_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .bit_tick  (bit_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (maint_wr),
        .wr_data   (maint_wdata),
        .port_en   (mgmt_en),
        .rise_tick (rise_tick),
        .bit_tick  (bit_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .start     (start),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .maint_q   (maint_rdata)
    );

    assign mgmt_idle = !busy;

    logic [CYC_W-1:0] busy_cyc;
    logic [CYC_W-1:0] busy_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cyc <= '0;
            busy_exp <= '0;
        end else begin
            busy_cyc <= busy ? busy_cyc + 1'b1 : '0;
            if (maint_wr && mgmt_en && mgmt_idle)
                busy_exp <= CYC_W'(FRAME_LEN * div_ratio(mdc_div_sel));
        end
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_idle) |-> (busy_cyc == busy_exp));

endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b1;
    logic [1:0]  mdc_div_sel = 2'd0;
    logic        maint_wr = 1'b0;
    logic [31:0] maint_wdata = '0;
    logic [31:0] maint_rdata;
    logic        mgmt_idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] cap;
    int          oe_cnt;
    int          rise_cnt;
    bit          phy_on;
    logic [15:0] phy_val;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .mdc_div_sel(mdc_div_sel),
        .maint_wr(maint_wr), .maint_wdata(maint_wdata), .maint_rdata(maint_rdata),
        .mgmt_idle(mgmt_idle), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe)
    );

    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap    = {cap[62:0], mdio_o};
            oe_cnt = oe_cnt + 1;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (phy_on && rise_cnt >= 48 && rise_cnt <= 63)
            mdio_i = phy_val[63 - rise_cnt];
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] cmd, input int intr_at,
                             input logic [31:0] intr_cmd,
                             output int busy, output int hi);
        cap      = '0;
        oe_cnt   = 0;
        rise_cnt = 0;
        busy     = 0;
        hi       = 0;
        @(negedge clk);
        maint_wr    = 1'b1;
        maint_wdata = cmd;
        @(negedge clk);
        maint_wr = 1'b0;
        while (!mgmt_idle && busy < 10000) begin
            busy++;
            if (mdc) hi++;
            maint_wr = (busy == intr_at);
            if (busy == intr_at) maint_wdata = intr_cmd;
            @(negedge clk);
        end
        maint_wr = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int busy, hi;
        logic [31:0] cmd, exp_rd;
        phy_on  = 1'b0;
        phy_val = '0;
        cap = '0; oe_cnt = 0; rise_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(mgmt_idle == 1'b1, "R10", "idle", 64'(mgmt_idle), 64'd1);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10", "mdc/oe", {mdc, mdio_oe}, 64'd0);
        chk(maint_rdata == 32'h0, "R10", "rdata", 64'(maint_rdata), 64'd0);

        // R4 R5 R3 write frame at every divider code
        for (int c = 0; c < 4; c++) begin
            int dv;
            dv = (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 32 : 48;
            mdc_div_sel = 2'(c);
            cmd = mk_cmd(1'b0, 5'(3 + c), 5'(9 + c), 16'hC35A ^ 16'(c * 16'h1111));
            run_frame(cmd, -1, '0, busy, hi);
            chk(busy == 64 * dv, "R3", "busy cycles", 64'(busy), 64'(64 * dv));
            chk(hi == 32 * dv, "R4", "mdc high cycles", 64'(hi), 64'(32 * dv));
            chk(cap == {32'hFFFF_FFFF, cmd}, "R5", "write frame", cap, {32'hFFFF_FFFF, cmd});
            chk(oe_cnt == 64, "R5", "driven bits", 64'(oe_cnt), 64'd64);
            chk(maint_rdata == cmd, "R1", "rdata after write", 64'(maint_rdata), 64'(cmd));
            chk(mgmt_idle && !mdc && !mdio_oe, "R9", "idle outputs",
                {mgmt_idle, mdc, mdio_oe}, 64'b100);
        end

        // R6 R7 R8 read sweep over every PHY address
        mdc_div_sel = 2'd0;
        for (int a = 0; a < 32; a++) begin
            phy_on  = (a == 5) || (a == 17) || (a == 31);
            phy_val = 16'(a * 16'h0421 + 16'h1808) ^ 16'h5A5A;
            cmd = mk_cmd(1'b1, 5'(a), 5'(a ^ 3), 16'h0000);
            run_frame(cmd, -1, '0, busy, hi);
            exp_rd = {cmd[31:16], phy_on ? phy_val : 16'hFFFF};
            chk(oe_cnt == 46, "R6", "driven bits on read", 64'(oe_cnt), 64'd46);
            chk(cap[45:0] == {32'hFFFF_FFFF, cmd[31:18]}, "R6", "read header",
                64'(cap[45:0]), 64'({32'hFFFF_FFFF, cmd[31:18]}));
            if (phy_on)
                chk(maint_rdata == exp_rd, "R7", "read data", 64'(maint_rdata), 64'(exp_rd));
            else
                chk(maint_rdata == exp_rd, "R8", "no-PHY read", 64'(maint_rdata), 64'(exp_rd));
            chk(busy == 512, "R3", "read busy cycles", 64'(busy), 64'd512);
        end
        phy_on = 1'b0;

        // R2 write during a running frame is ignored
        cmd = mk_cmd(1'b0, 5'd12, 5'd4, 16'hBEEF);
        run_frame(cmd, 100, mk_cmd(1'b1, 5'd1, 5'd1, 16'h1234), busy, hi);
        chk(cap == {32'hFFFF_FFFF, cmd}, "R2", "frame after intrusion", cap, {32'hFFFF_FFFF, cmd});
        chk(maint_rdata == cmd, "R2", "rdata after intrusion", 64'(maint_rdata), 64'(cmd));
        chk(busy == 512, "R2", "busy length after intrusion", 64'(busy), 64'd512);
        repeat (5) @(negedge clk);
        chk(mgmt_idle == 1'b1, "R2", "no second frame", 64'(mgmt_idle), 64'd1);

        // R2 write with port disabled is ignored
        mgmt_en = 1'b0;
        @(negedge clk);
        maint_wr    = 1'b1;
        maint_wdata = mk_cmd(1'b0, 5'd2, 5'd2, 16'h0F0F);
        @(negedge clk);
        maint_wr = 1'b0;
        begin
            bit stayed;
            stayed = 1'b1;
            for (int k = 0; k < 20; k++) begin
                if (!mgmt_idle || mdc || mdio_oe) stayed = 1'b0;
                @(negedge clk);
            end
            chk(stayed, "R2", "disabled port stays idle", 64'(stayed), 64'd1);
        end
        chk(maint_rdata == cmd, "R2", "rdata while disabled", 64'(maint_rdata), 64'(cmd));
        mgmt_en = 1'b1;

        // R1 accepted again after re-enable
        cmd = mk_cmd(1'b0, 5'd30, 5'd31, 16'h0001);
        run_frame(cmd, -1, '0, busy, hi);
        chk(maint_rdata == cmd, "R1", "write after re-enable", 64'(maint_rdata), 64'(cmd));
        chk(busy == 512, "R3", "busy after re-enable", 64'(busy), 64'd512);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule